// File: doc/BRIEF.md
# Frame Alignment Character Inserter

This block sits in a serial converter-link transmit path, after the stage that packs samples into two-octet frames and before the 8B/10B encoder. It watches the final octet of each frame. When a replacement rule is met, it swaps that octet for an alignment control character. The receiver then finds these characters at fixed positions in the stream and uses them to confirm frame and multiframe alignment.

The rule depends on whether the payload is scrambled. In the scrambled case, the final octet is compared with the original final octet of the frame before it. In the plain case, it is compared with a fixed code value. The rule also depends on whether the frame closes a multiframe. An internal frame counter finds multiframe boundaries, and it wraps at a configured number of frames. The output has a fixed one-cycle latency and carries the octet, a control-character flag for the encoder, and the frame and multiframe boundary markers.

Top module: `fac_inserter`

## Requirements
- R1: Every output appears exactly one clock cycle after the input that produced it: valid_o follows valid_i, and eof_o follows valid_i && eof_i.
- R2: An accepted octet that is not the final octet of its frame leaves unchanged with ctrl_o = 0.
- R3: With scr_en_i = 1, the final octet of the frame that closes a multiframe is replaced by 8'h7C with ctrl_o = 1 when it equals the stored previous final octet.
- R4: With scr_en_i = 1, the final octet of any other frame is replaced by 8'hFC with ctrl_o = 1 when it equals the stored previous final octet.
- R5: With scr_en_i = 0, the final octet of a multiframe-closing frame gets ctrl_o = 1 (data 8'h7C) only when it equals 8'h7C; the value 8'hFC in that slot passes as data.
- R6: With scr_en_i = 0, the final octet of any other frame gets ctrl_o = 1 (data 8'hFC) only when it equals 8'hFC; the value 8'h7C in that slot passes as data.
- R7: The stored previous final octet is the original input octet, taken before any replacement, and it is updated at every accepted frame end.
- R8: After reset no previous final octet is stored, so in scrambled mode the first frame end after reset is never replaced.
- R9: Frames per multiframe K comes from cfg_k_i. A value of 0 counts as 1 and values above 32 count as 32. The counter starts at frame 0 after reset and wraps after K frame ends. eomf_o is 1 exactly on the final octet of frame K-1.
- R10: While reset is asserted, and until the first accepted octet, all outputs are 0.
- R11: A cycle with valid_i = 0 produces valid_o = 0 with all other outputs 0, and it changes neither the frame counter nor the stored octet, even when eof_i = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_k_i | input | 6 | Frames per multiframe (1..32, clamped) |
| scr_en_i | input | 1 | Payload is scrambled |
| valid_i | input | 1 | Input octet valid |
| data_i | input | 8 | Input octet |
| eof_i | input | 1 | Input octet is the last of its frame |
| valid_o | output | 1 | Output octet valid |
| data_o | output | 8 | Output octet or control code |
| ctrl_o | output | 1 | data_o is a control character |
| eof_o | output | 1 | Output octet ends a frame |
| eomf_o | output | 1 | Output octet ends a multiframe |

## Verification
The bench targets the mode and boundary crossings:
- **Replaced octets as history.** If the stored comparison value held a replaced octet rather than the original, the bench sees repeated equal octets stop being flagged after the first hit.
- **Wrong code table.** If the plain-mode rule used the wrong code for the frame position, the bench sees 0x7C and 0xFC flagged in the wrong slots.
- **Missing history at startup.** If the previous-octet valid flag were not kept, the first scrambled frame after reset would compare against the reset value.
- **Counter faults.** Idle cycles carrying a stray end-of-frame would desynchronise a counter that did not qualify on valid. A clamp fault or an off-by-one wrap would put the multiframe marker on the wrong frame for K = 1, K = 0 and an over-range K.

// File: rtl/fac_pkg.sv
`timescale 1ns/1ps
package fac_pkg;
  localparam int OCT_W = 8;
  localparam logic [OCT_W-1:0] CHAR_MF_END = 8'h7C;  // replaces last octet of multiframe
  localparam logic [OCT_W-1:0] CHAR_FR_END = 8'hFC;  // replaces last octet of other frames

  typedef struct packed {
    logic             valid;
    logic [OCT_W-1:0] data;
    logic             ctrl;
    logic             eof;
    logic             eomf;
  } fac_out_t;
endpackage

// File: rtl/fac_mf_counter.sv
`timescale 1ns/1ps
module fac_mf_counter #(
  parameter int K_MAX = 32,
  localparam int KW   = $clog2(K_MAX + 1),
  localparam int CNTW = (K_MAX > 1) ? $clog2(K_MAX) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [KW-1:0] cfg_k_i,
  input  logic          adv_i,
  output logic          last_o
);
  logic [KW-1:0]   k_eff;
  logic [CNTW-1:0] cnt_q;

  always_comb begin
    if (cfg_k_i == '0)                k_eff = KW'(1);
    else if (cfg_k_i > KW'(K_MAX))    k_eff = KW'(K_MAX);
    else                              k_eff = cfg_k_i;
  end

  // >= tolerates a K lowered while the count is already past it
  assign last_o = (KW'(cnt_q) + KW'(1)) >= k_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (adv_i)  cnt_q <= last_o ? '0 : cnt_q + CNTW'(1);
  end
endmodule

// File: rtl/fac_prev_tracker.sv
`timescale 1ns/1ps
module fac_prev_tracker
  import fac_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic [OCT_W-1:0] data_i,
  output logic [OCT_W-1:0] prev_o,
  output logic             prev_vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_o     <= '0;
      prev_vld_o <= 1'b0;
    end else if (upd_i) begin
      prev_o     <= data_i;  // original octet, never the substitute
      prev_vld_o <= 1'b1;
    end
  end
endmodule

// File: rtl/fac_match.sv
`timescale 1ns/1ps
module fac_match
  import fac_pkg::*;
(
  input  logic             eof_i,
  input  logic             scr_en_i,
  input  logic             last_mf_i,
  input  logic [OCT_W-1:0] data_i,
  input  logic [OCT_W-1:0] prev_i,
  input  logic             prev_vld_i,
  output logic             hit_o,
  output logic [OCT_W-1:0] char_o
);
  logic scr_hit, raw_hit;

  assign char_o  = last_mf_i ? CHAR_MF_END : CHAR_FR_END;
  assign scr_hit = prev_vld_i && (data_i == prev_i);
  assign raw_hit = (data_i == char_o);
  assign hit_o   = eof_i && (scr_en_i ? scr_hit : raw_hit);
endmodule

// File: rtl/fac_inserter.sv
`timescale 1ns/1ps
module fac_inserter
  import fac_pkg::*;
#(
  parameter int K_MAX = 32,
  localparam int KW   = $clog2(K_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [KW-1:0]    cfg_k_i,
  input  logic             scr_en_i,
  input  logic             valid_i,
  input  logic [OCT_W-1:0] data_i,
  input  logic             eof_i,
  output logic             valid_o,
  output logic [OCT_W-1:0] data_o,
  output logic             ctrl_o,
  output logic             eof_o,
  output logic             eomf_o
);
  logic             frame_end;
  logic             last_mf;
  logic [OCT_W-1:0] prev_oct;
  logic             prev_vld;
  logic             hit;
  logic [OCT_W-1:0] char_val;
  fac_out_t         out_d, out_q;

  assign frame_end = valid_i && eof_i;

  fac_mf_counter #(.K_MAX(K_MAX)) u_mf_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cfg_k_i (cfg_k_i),
    .adv_i   (frame_end),
    .last_o  (last_mf)
  );

  fac_prev_tracker u_prev (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_i      (frame_end),
    .data_i     (data_i),
    .prev_o     (prev_oct),
    .prev_vld_o (prev_vld)
  );

  fac_match u_match (
    .eof_i      (frame_end),
    .scr_en_i   (scr_en_i),
    .last_mf_i  (last_mf),
    .data_i     (data_i),
    .prev_i     (prev_oct),
    .prev_vld_i (prev_vld),
    .hit_o      (hit),
    .char_o     (char_val)
  );

  always_comb begin
    out_d = '0;
    if (valid_i) begin
      out_d.valid = 1'b1;
      out_d.data  = hit ? char_val : data_i;
      out_d.ctrl  = hit;
      out_d.eof   = eof_i;
      out_d.eomf  = eof_i && last_mf;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else         out_q <= out_d;
  end

  assign valid_o = out_q.valid;
  assign data_o  = out_q.data;
  assign ctrl_o  = out_q.ctrl;
  assign eof_o   = out_q.eof;
  assign eomf_o  = out_q.eomf;
endmodule

// File: rtl/fac_inserter_chk.sv
`timescale 1ns/1ps
module fac_inserter_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scr_en_i,
  input logic       valid_i,
  input logic [7:0] data_i,
  input logic       eof_i,
  input logic       valid_o,
  input logic [7:0] data_o,
  input logic       ctrl_o,
  input logic       eof_o,
  input logic       eomf_o
);
  AST_LATENCY_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);  // R1
  AST_LATENCY_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && eof_i) |=> eof_o);  // R1
  AST_PASS_MID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !eof_i) |=> (!ctrl_o && data_o == $past(data_i)));  // R2
  AST_CTRL_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o |-> (eof_o && (eomf_o ? data_o == 8'h7C : data_o == 8'hFC)));  // R3
  AST_RAW_NO_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && eof_i && !scr_en_i && data_i != 8'h7C && data_i != 8'hFC) |=> !ctrl_o);  // R5
  AST_EOMF_IN_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eomf_o |-> eof_o);  // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !ctrl_o && !eof_o && !eomf_o && data_o == 8'h00));  // R11
endmodule

bind fac_inserter fac_inserter_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scr_en_i (scr_en_i),
  .valid_i  (valid_i),
  .data_i   (data_i),
  .eof_i    (eof_i),
  .valid_o  (valid_o),
  .data_o   (data_o),
  .ctrl_o   (ctrl_o),
  .eof_o    (eof_o),
  .eomf_o   (eomf_o)
);

// File: tb/fac_inserter_tb_top.sv
`timescale 1ns/1ps
module fac_inserter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] cfg_k = 6'd2;
  logic       scr_en = 1'b0;
  logic       valid = 1'b0;
  logic [7:0] data = 8'h00;
  logic       eof = 1'b0;
  logic       valid_o, ctrl_o, eof_o, eomf_o;
  logic [7:0] data_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  fac_inserter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_k_i(cfg_k), .scr_en_i(scr_en),
    .valid_i(valid), .data_i(data), .eof_i(eof),
    .valid_o(valid_o), .data_o(data_o), .ctrl_o(ctrl_o),
    .eof_o(eof_o), .eomf_o(eomf_o)
  );

  // packed: {valid,eof,scr,data[7:0], exp_valid,exp_ctrl,exp_eof,exp_eomf,exp_data[7:0]}
  localparam int NV = 23;
  localparam logic [22:0] VEC [NV] = '{
    {3'b101, 8'h11, 4'b1000, 8'h11},  // R2
    {3'b111, 8'hA5, 4'b1010, 8'hA5},  // R8 first frame, no history
    {3'b101, 8'h22, 4'b1000, 8'h22},
    {3'b111, 8'hA5, 4'b1111, 8'h7C},  // R3
    {3'b101, 8'h33, 4'b1000, 8'h33},
    {3'b111, 8'hA5, 4'b1110, 8'hFC},  // R4 R7 R9 wrap
    {3'b101, 8'h44, 4'b1000, 8'h44},
    {3'b111, 8'h5A, 4'b1011, 8'h5A},
    {3'b011, 8'h5A, 4'b0000, 8'h00},  // R11 idle with eof
    {3'b101, 8'h55, 4'b1000, 8'h55},
    {3'b111, 8'h5A, 4'b1110, 8'hFC},  // R11 counter held
    {3'b100, 8'h7C, 4'b1000, 8'h7C},  // R2 plain
    {3'b110, 8'hFC, 4'b1011, 8'hFC},  // R5 FC in mf slot
    {3'b100, 8'h66, 4'b1000, 8'h66},
    {3'b110, 8'hFC, 4'b1110, 8'hFC},  // R6
    {3'b100, 8'h77, 4'b1000, 8'h77},
    {3'b110, 8'h7C, 4'b1111, 8'h7C},  // R5
    {3'b100, 8'h88, 4'b1000, 8'h88},
    {3'b110, 8'h7C, 4'b1010, 8'h7C},  // R6 7C in frame slot
    {3'b100, 8'h99, 4'b1000, 8'h99},
    {3'b110, 8'hFC, 4'b1011, 8'hFC},
    {3'b101, 8'h01, 4'b1000, 8'h01},
    {3'b111, 8'hFC, 4'b1110, 8'hFC}   // R7 history kept across modes
  };

  task automatic check(string req, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: act {v,c,eof,eomf,data}=%03h exp=%03h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] outs();
    return {valid_o, ctrl_o, eof_o, eomf_o, data_o};
  endfunction

  // drive 2 ns after posedge, wait one edge, outputs then hold that octet's result
  task automatic step(logic v, logic e, logic s, logic [7:0] d);
    valid = v; eof = e; scr_en = s; data = d;
    @(posedge clk); #2;
  endtask

  task automatic do_reset(logic [5:0] k);
    rst_n = 1'b0; valid = 1'b0; eof = 1'b0; cfg_k = k;
    @(posedge clk); #2;
    rst_n = 1'b1;
    @(posedge clk); #2;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int eomf_cnt;
    @(posedge clk); #2;
    check("R10 in reset", outs(), 12'h000);
    rst_n = 1'b1;
    @(posedge clk); #2;
    check("R10 after release", outs(), 12'h000);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][22], VEC[i][21], VEC[i][20], VEC[i][19:12]);
      check($sformatf("R1 vector %0d", i), outs(), VEC[i][11:0]);
    end

    // reset drops history: repeat last stored octet in scrambled mode
    do_reset(6'd2);
    step(1, 0, 1, 8'h10);
    step(1, 1, 1, 8'h00);
    check("R8 reset clears history", outs(), 12'hA00);
    step(1, 0, 1, 8'h10);
    step(1, 1, 1, 8'h00);
    check("R3 after history", outs(), 12'hF7C);

    // K=1: every frame closes a multiframe
    do_reset(6'd1);
    step(1, 1, 1, 8'h3C);
    check("R9 K=1 first", outs(), 12'hB3C);
    step(1, 1, 1, 8'h3C);
    check("R9 K=1 repeat", outs(), 12'hF7C);

    // K=0 clamps to 1
    do_reset(6'd0);
    step(1, 1, 0, 8'hFC);
    check("R9 K=0 clamp", outs(), 12'hBFC);
    step(1, 1, 0, 8'h7C);
    check("R9 K=0 clamp mf code", outs(), 12'hF7C);

    // K=40 clamps to 32
    do_reset(6'd40);
    eomf_cnt = 0;
    for (int f = 0; f < 64; f++) begin
      step(1, 0, 0, 8'h00);
      step(1, 1, 0, 8'h00);
      if (eomf_o) eomf_cnt++;
      if (f == 30 || f == 31 || f == 32 || f == 63)
        check($sformatf("R9 K=32 frame %0d", f), outs(),
              (f == 31 || f == 63) ? 12'hB00 : 12'hA00);
    end
    check("R9 K=32 eomf count", 12'(eomf_cnt), 12'd2);

    step(0, 0, 0, 8'h00);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule